// File: doc/BRIEF.md
# ADC External Trigger Chain Controller

This block turns trigger events into timed sequences of conversion requests for two ADCs. Eight trigger queues are split into two halves of four. The lower half feeds ADC interface 0 and the upper half feeds ADC interface 1. Each queue holds a chain of up to eight steps. Each step carries a one-hot slot-select word that names the ADC logic channel to convert. A started chain first waits an initial delay. It then issues its steps one at a time. Between steps it waits for the ADC's completion strobe and then an interval delay.

Each half has a sequencer that serves one chain at a time. When several queues of a half are pending together, a fixed-priority arbiter picks the lowest index. An event that arrives while its own chain is still running is kept as pending and runs again later. A global mirror setting lets each lower-half trigger also start the matching upper-half queue (0→4, 1→5, 2→6, 3→7). Both ADCs then convert from one event.

Configuration is written through a simple write port. The control, delay and chain words of each queue sit at an address made of the queue number and a sub-address.

Top module: `adc_trig_chain_ctrl`

## Requirements
- R1: After reset, `adc_req`, `adc_hts` and `chain_done` are all zero. Every queue is in hardware mode with a length code of 0, an initial delay of 0 and an interval of 0.
- R2: A queue with mode bit 0 (bit 4 of its control word) starts only on a `trig_hw` pulse and ignores `trig_sw`. A queue with mode bit 1 starts only on a `trig_sw` strobe and ignores `trig_hw`.
- R3: Queues 0–3 issue requests only on interface 0, and queues 4–7 only on interface 1.
- R4: When the mirror bit is set (bit 0 at address 0x40), an accepted event on queue t (t < 4) also starts queue t+4 on interface 1. Queue t+4 uses its own configuration.
- R5: The length code (control word bits [2:0]) is the step count minus one: code 0 runs one step and code 7 runs eight.
- R6: Address layout: bits [5:3] give the queue number and bits [2:0] the sub-address. Sub 0 is the control word, sub 1 the delay word, and subs 2..5 hold chain pairs. Pair p keeps step 2p in bits [7:0] and step 2p+1 in bits [15:8]. During each request, `adc_hts` carries the stored byte of the current step, in which bit x selects logic channel x.
- R7: Let the event be sampled at clock edge E, and let the initial delay (delay word bits [7:0]) be D, with 0 allowed. The first request is then raised at edge E+2+D.
- R8: Let the ADC completion of a step that is not the last be sampled at edge X. The next request is raised at edge X+1+I', where I' is the interval (delay word bits [15:8]) and an interval of 0 counts as 1.
- R9: Among queues of one half that are pending together, the lowest index is served first. The others stay pending and are served afterwards.
- R10: An event on a queue whose chain is running is kept and starts a fresh run of that chain once the sequencer is free.
- R11: One cycle after the completion of the last step is sampled, the `chain_done` bit of that queue pulses high for one cycle. It never pulses without a completion.
- R12: `adc_req` is a one-cycle strobe. No further request is raised on an interface until its completion has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_hw | input | 8 | Hardware trigger pulses, one per queue |
| trig_sw | input | 8 | Software trigger strobes, one per queue |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 7 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| adc_done | input | 2 | Completion strobe from each ADC |
| adc_req | output | 2 | Conversion request strobe to each ADC |
| adc_hts | output | 16 | One-hot slot select, 8 bits per interface (interface 1 in bits [15:8]) |
| chain_done | output | 8 | Per-queue chain completion pulse |

## Verification
Two events can land in the same cycle. The first is a fresh event on a queue, which sets its pending bit. The second is the arbiter's grant of that same queue, which clears the bit. The bench provokes this by firing a trigger again while its chain runs, and by firing two queues of one half together. It then counts completion pulses and compares the order in which chains finish. In mirror mode both interfaces run their own schedules at the same time. The bench follows each interface against its own arithmetic timeline, cycle by cycle.

// File: rtl/adc_tc_pkg.sv
package adc_tc_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_DELAY = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_t;

  localparam int SUB_CTRL  = 0;
  localparam int SUB_DLY   = 1;
  localparam int SUB_PAIR0 = 2;
  localparam int MODE_BIT  = 4;

endpackage

// File: rtl/adc_tc_cfg.sv
module adc_tc_cfg
  import adc_tc_pkg::*;
#(
  parameter int N_TRIG    = 8,
  parameter int CHAIN_MAX = 8,
  parameter int HTS_W     = 8,
  parameter int DLY_W     = 8,
  parameter int DATA_W    = 32,
  parameter int N_RD      = 2,
  localparam int TW       = $clog2(N_TRIG),
  localparam int EW       = $clog2(CHAIN_MAX),
  localparam int PAIRS    = CHAIN_MAX / 2,
  localparam int SUB_W    = $clog2(SUB_PAIR0 + PAIRS),
  localparam int ADDR_W   = 1 + TW + SUB_W,
  localparam int IW       = TW + EW
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DATA_W-1:0]                wdata,
  output logic [N_TRIG-1:0]                sw_mode,
  output logic [N_TRIG-1:0][EW-1:0]        len_m1,
  output logic [N_TRIG-1:0][DLY_W-1:0]     ini_dly,
  output logic [N_TRIG-1:0][DLY_W-1:0]     ivl_dly,
  output logic                             sync_en,
  input  logic [N_RD-1:0][IW-1:0]          rd_idx,
  output logic [N_RD-1:0][HTS_W-1:0]       rd_hts
);

  logic             glb;
  logic [TW-1:0]    tsel;
  logic [SUB_W-1:0] sub;
  logic [SUB_W-1:0] pidx;
  logic             pair_hit;
  logic             unused_cfg;

  logic [HTS_W-1:0] chain_q [N_TRIG*CHAIN_MAX];

  assign glb        = addr[ADDR_W-1];
  assign tsel       = addr[SUB_W +: TW];
  assign sub        = addr[SUB_W-1:0];
  assign pidx       = sub - SUB_W'(SUB_PAIR0);
  assign pair_hit   = we && !glb && (sub >= SUB_W'(SUB_PAIR0)) && (pidx < SUB_W'(PAIRS));
  assign unused_cfg = ^wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_mode <= '0;
      len_m1  <= '0;
      ini_dly <= '0;
      ivl_dly <= '0;
      sync_en <= 1'b0;
    end else if (we) begin
      if (glb) begin
        sync_en <= wdata[0];
      end else if (sub == SUB_W'(SUB_CTRL)) begin
        len_m1[tsel]  <= wdata[EW-1:0];
        sw_mode[tsel] <= wdata[MODE_BIT];
      end else if (sub == SUB_W'(SUB_DLY)) begin
        ini_dly[tsel] <= wdata[DLY_W-1:0];
        ivl_dly[tsel] <= wdata[DLY_W +: DLY_W];
      end
    end
  end

  // chain table: two steps per write, no reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (pair_hit) begin
      chain_q[{tsel, pidx[EW-2:0], 1'b0}] <= wdata[HTS_W-1:0];
      chain_q[{tsel, pidx[EW-2:0], 1'b1}] <= wdata[HTS_W +: HTS_W];
    end
  end

  generate
    for (genvar k = 0; k < N_RD; k++) begin : g_rd
      assign rd_hts[k] = chain_q[rd_idx[k]];
    end
  endgenerate

endmodule

// File: rtl/adc_tc_arb.sv
module adc_tc_arb #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    gnt = '0;
    idx = '0;
    any = |req;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        gnt    = '0;
        gnt[k] = 1'b1;
        idx    = IW'(k);
      end
    end
  end

endmodule

// File: rtl/adc_tc_seq.sv
module adc_tc_seq
  import adc_tc_pkg::*;
#(
  parameter int QN    = 4,
  parameter int HTS_W = 8,
  parameter int DLY_W = 8,
  parameter int EW    = 3,
  localparam int QW   = (QN > 1) ? $clog2(QN) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [QN-1:0]              evt,
  input  logic [QN-1:0][EW-1:0]      len_m1,
  input  logic [QN-1:0][DLY_W-1:0]   ini,
  input  logic [QN-1:0][DLY_W-1:0]   ivl,
  input  logic [HTS_W-1:0]           rd_hts,
  input  logic                       adc_done,
  output logic [QW-1:0]              rd_q,
  output logic [EW-1:0]              rd_e,
  output logic                       adc_req,
  output logic [HTS_W-1:0]           adc_hts,
  output logic [QN-1:0]              chain_done
);

  sq_state_t        st;
  logic [QN-1:0]    pend;
  logic [QN-1:0]    gnt;
  logic [QW-1:0]    gidx;
  logic             gany;
  logic             take;
  logic [QW-1:0]    cur;
  logic [EW-1:0]    elem;
  logic [DLY_W-1:0] cnt;
  logic [DLY_W-1:0] ivl_eff;

  adc_tc_arb #(.N(QN)) u_arb (
    .req (pend),
    .gnt (gnt),
    .idx (gidx),
    .any (gany)
  );

  assign take    = (st == SQ_IDLE) && gany;
  assign ivl_eff = (ivl[cur] == '0) ? DLY_W'(1) : ivl[cur];
  assign rd_q    = cur;
  assign rd_e    = elem;

  // a fresh event wins over the clear of a grant in the same cycle
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~(take ? gnt : '0)) | evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      cur        <= '0;
      elem       <= '0;
      cnt        <= '0;
      adc_req    <= 1'b0;
      adc_hts    <= '0;
      chain_done <= '0;
    end else begin
      adc_req    <= 1'b0;
      chain_done <= '0;
      case (st)
        SQ_IDLE: begin
          if (gany) begin
            cur  <= gidx;
            elem <= '0;
            cnt  <= ini[gidx];
            st   <= SQ_DELAY;
          end
        end
        SQ_DELAY: begin
          if (cnt == '0) begin
            adc_req <= 1'b1;
            adc_hts <= rd_hts;
            st      <= SQ_WAIT;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_WAIT: begin
          if (adc_done) begin
            if (elem == len_m1[cur]) begin
              chain_done[cur] <= 1'b1;
              st              <= SQ_IDLE;
            end else begin
              elem <= elem + 1'b1;
              cnt  <= ivl_eff;
              st   <= SQ_DELAY;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R12
  req_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    adc_req |=> !adc_req);

  // R12
  no_early_req_chk: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_WAIT && !adc_done) |=> !adc_req);

  // R11
  done_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (|chain_done) |-> $past(adc_done));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chain_done));

  // R9
  grant_valid_chk: assert property (@(posedge clk) disable iff (rst)
    take |-> ($onehot(gnt) && ((gnt & ~pend) == '0)));

  // R10
  pend_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (st != SQ_IDLE && (|pend)) |=> (|pend));

endmodule

// File: rtl/adc_trig_chain_ctrl.sv
module adc_trig_chain_ctrl
  import adc_tc_pkg::*;
#(
  parameter int N_TRIG    = 8,
  parameter int CHAIN_MAX = 8,
  parameter int HTS_W     = 8,
  parameter int DLY_W     = 8,
  parameter int DATA_W    = 32,
  localparam int N_IF     = 2,
  localparam int TW       = $clog2(N_TRIG),
  localparam int SUB_W    = $clog2(SUB_PAIR0 + CHAIN_MAX / 2),
  localparam int ADDR_W   = 1 + TW + SUB_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_TRIG-1:0]       trig_hw,
  input  logic [N_TRIG-1:0]       trig_sw,
  input  logic                    cfg_we,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_W-1:0]       cfg_wdata,
  input  logic [N_IF-1:0]         adc_done,
  output logic [N_IF-1:0]         adc_req,
  output logic [N_IF*HTS_W-1:0]   adc_hts,
  output logic [N_TRIG-1:0]       chain_done
);

  localparam int HALF = N_TRIG / N_IF;
  localparam int EW   = $clog2(CHAIN_MAX);
  localparam int QW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int IW   = TW + EW;

  logic [N_TRIG-1:0]            sw_mode;
  logic [N_TRIG-1:0][EW-1:0]    len_m1;
  logic [N_TRIG-1:0][DLY_W-1:0] ini_dly;
  logic [N_TRIG-1:0][DLY_W-1:0] ivl_dly;
  logic                         sync_en;
  logic [N_IF-1:0][IW-1:0]      rd_idx;
  logic [N_IF-1:0][HTS_W-1:0]   rd_hts;
  logic [N_IF-1:0][QW-1:0]      rd_q;
  logic [N_IF-1:0][EW-1:0]      rd_e;
  logic [N_TRIG-1:0]            accept;
  logic [N_TRIG-1:0]            evt;

  adc_tc_cfg #(
    .N_TRIG    (N_TRIG),
    .CHAIN_MAX (CHAIN_MAX),
    .HTS_W     (HTS_W),
    .DLY_W     (DLY_W),
    .DATA_W    (DATA_W),
    .N_RD      (N_IF)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .we      (cfg_we),
    .addr    (cfg_addr),
    .wdata   (cfg_wdata),
    .sw_mode (sw_mode),
    .len_m1  (len_m1),
    .ini_dly (ini_dly),
    .ivl_dly (ivl_dly),
    .sync_en (sync_en),
    .rd_idx  (rd_idx),
    .rd_hts  (rd_hts)
  );

  assign accept = (sw_mode & trig_sw) | (~sw_mode & trig_hw);

  generate
    for (genvar t = 0; t < N_TRIG; t++) begin : g_evt
      if (t >= HALF) begin : g_hi
        assign evt[t] = accept[t] | (sync_en & accept[t-HALF]);
      end else begin : g_lo
        assign evt[t] = accept[t];
      end
    end

    for (genvar i = 0; i < N_IF; i++) begin : g_if
      assign rd_idx[i] = {TW'(i * HALF) + TW'(rd_q[i]), rd_e[i]};

      adc_tc_seq #(
        .QN    (HALF),
        .HTS_W (HTS_W),
        .DLY_W (DLY_W),
        .EW    (EW)
      ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt[i*HALF +: HALF]),
        .len_m1     (len_m1[i*HALF +: HALF]),
        .ini        (ini_dly[i*HALF +: HALF]),
        .ivl        (ivl_dly[i*HALF +: HALF]),
        .rd_hts     (rd_hts[i]),
        .adc_done   (adc_done[i]),
        .rd_q       (rd_q[i]),
        .rd_e       (rd_e[i]),
        .adc_req    (adc_req[i]),
        .adc_hts    (adc_hts[i*HTS_W +: HTS_W]),
        .chain_done (chain_done[i*HALF +: HALF])
      );
    end
  endgenerate

endmodule

// File: tb/adc_trig_chain_ctrl_tb.sv
module adc_trig_chain_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  trig_hw = '0;
  logic [7:0]  trig_sw = '0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  done_m = '0;
  logic [1:0]  done_a = '0;
  logic [1:0]  adc_req;
  logic [15:0] adc_hts;
  logic [7:0]  chain_done;
  logic        auto_on = 1'b0;

  int vecs = 0;
  int errs = 0;
  int len_c [8];
  int ini_c [8];
  int ivl_c [8];
  bit sw_c  [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_chain_ctrl u_dut (
    .clk        (clk),
    .rst        (rst),
    .trig_hw    (trig_hw),
    .trig_sw    (trig_sw),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .adc_done   (done_m | done_a),
    .adc_req    (adc_req),
    .adc_hts    (adc_hts),
    .chain_done (chain_done)
  );

  task automatic chk(input string tag, input int act, input int expv);
    vecs++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  function automatic int hts_of(input int t, input int e);
    return 1 << ((t + e) % 8);
  endfunction

  task automatic cfg_wr(input int a, input int d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = 7'(a);
    cfg_wdata = 32'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic program_q(input int t, input int len, input bit sw, input int ini, input int ivl);
    len_c[t] = len; ini_c[t] = ini; ivl_c[t] = ivl; sw_c[t] = sw;
    cfg_wr(t * 8, len | (int'(sw) << 4));
    cfg_wr(t * 8 + 1, ini | (ivl << 8));
    for (int p = 0; p < 4; p++)
      cfg_wr(t * 8 + 2 + p, hts_of(t, 2 * p) | (hts_of(t, 2 * p + 1) << 8));
  endtask

  // Cycle-exact scoreboard of one event, bench acting as the ADC.
  task automatic run_case(input int t, input bit sync);
    int  tr [2];
    int  nreq [2];
    int  elem [2];
    int  dn [2];
    int  fin [2];
    bit  act [2];
    string tg;
    tr[0] = (t < 4) ? t : -1;
    tr[1] = (t >= 4) ? t : (sync ? t + 4 : -1);
    for (int i = 0; i < 2; i++) begin
      act[i]  = (tr[i] >= 0);
      elem[i] = 0;
      dn[i]   = -1;
      fin[i]  = -1;
      nreq[i] = act[i] ? ini_c[tr[i]] + 3 : -1;
    end
    @(negedge clk);
    if (sw_c[t]) trig_sw[t] = 1'b1; else trig_hw[t] = 1'b1;
    for (int n = 1; n < 400; n++) begin
      @(negedge clk);
      trig_hw = '0;
      trig_sw = '0;
      done_m  = '0;
      for (int i = 0; i < 2; i++) begin
        if (!act[i]) begin
          chk("R3 idle interface request", int'(adc_req[i]), 0);
        end else begin
          if (sync && i == 1 && t < 4) tg = "R4";
          else if (elem[i] == 0)       tg = "R7";
          else                         tg = "R8";
          chk({tg, " request timing"}, int'(adc_req[i]), int'(n == nreq[i]));
          if (n == nreq[i]) begin
            chk("R6 slot select", int'(adc_hts[i*8 +: 8]), hts_of(tr[i], elem[i]));
            dn[i] = n + LAT;
          end
          if (n == dn[i]) begin
            done_m[i] = 1'b1;
            if (elem[i] == len_c[tr[i]]) begin
              fin[i] = n + 1;
            end else begin
              elem[i] = elem[i] + 1;
              nreq[i] = n + ((ivl_c[tr[i]] == 0) ? 1 : ivl_c[tr[i]]) + 2;
            end
          end
          chk("R5 R11 chain done", int'(chain_done[tr[i]]), int'(n == fin[i]));
          if (n == fin[i]) act[i] = 1'b0;
        end
      end
      if (!act[0] && !act[1]) break;
    end
    chk("R5 chain finished", int'(act[0] | act[1]), 0);
  endtask

  task automatic quiet_window(input string tag, input int cycles);
    int seen;
    seen = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      trig_hw = '0;
      trig_sw = '0;
      seen = seen + int'(|adc_req) + int'(|chain_done);
    end
    chk(tag, seen, 0);
  endtask

  // ADC model for the multi-chain scenarios
  initial begin
    int cd [2];
    cd[0] = 0; cd[1] = 0;
    forever begin
      @(negedge clk);
      done_a = '0;
      if (auto_on) begin
        for (int i = 0; i < 2; i++) begin
          if (cd[i] == 1) done_a[i] = 1'b1;
          if (cd[i] > 0) cd[i] = cd[i] - 1;
          if (adc_req[i]) cd[i] = LAT;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL R12 watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int d1, d2, nreq, ndone;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset request", int'(adc_req), 0);
    chk("R1 reset slot select", int'(adc_hts), 0);
    chk("R1 reset chain done", int'(chain_done), 0);

    // sweep: every queue, every length, both modes, delays incl. 0
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l < 8; l++) begin
        program_q(t, l, bit'((t + l) % 2), (t + l) % 3, (t * 3 + l) % 3);
        run_case(t, 1'b0);
      end
    end

    // R4: mirror mode, upper queues with their own settings
    cfg_wr(64, 1);
    for (int t = 0; t < 4; t++) begin
      program_q(t, t + 1, bit'(t % 2), t, 1);
      program_q(t + 4, 3 - t, 1'b0, 2, 0);
      run_case(t, 1'b1);
    end
    cfg_wr(64, 0);
    program_q(1, 1, 1'b0, 0, 0);
    run_case(1, 1'b0);

    // R2: stimulus on the wrong trigger kind is ignored
    program_q(5, 0, 1'b0, 0, 1);
    @(negedge clk); trig_sw[5] = 1'b1;
    quiet_window("R2 sw strobe in hw mode", 30);
    program_q(2, 0, 1'b1, 0, 1);
    @(negedge clk); trig_hw[2] = 1'b1;
    quiet_window("R2 hw pulse in sw mode", 30);

    // R9: two queues of one half fire together
    auto_on = 1'b1;
    program_q(1, 1, 1'b0, 1, 1);
    program_q(2, 1, 1'b0, 1, 1);
    d1 = -1; d2 = -1; nreq = 0;
    @(negedge clk); trig_hw = 8'b0000_0110;
    for (int n = 1; n < 200; n++) begin
      @(negedge clk);
      trig_hw = '0;
      nreq = nreq + int'(adc_req[0]);
      if (chain_done[1] && d1 < 0) d1 = n;
      if (chain_done[2] && d2 < 0) d2 = n;
    end
    chk("R9 lower index served", int'(d1 > 0), 1);
    chk("R9 higher index after lower", int'(d2 > d1), 1);
    chk("R9 pending kept, total requests", nreq, 4);

    // R10: retrigger during a running chain
    program_q(6, 2, 1'b0, 0, 2);
    nreq = 0; ndone = 0;
    @(negedge clk); trig_hw[6] = 1'b1;
    for (int n = 1; n < 200; n++) begin
      @(negedge clk);
      trig_hw = '0;
      if (n == 4) trig_hw[6] = 1'b1;
      nreq  = nreq + int'(adc_req[1]);
      ndone = ndone + int'(chain_done[6]);
    end
    chk("R10 chain reruns", ndone, 2);
    chk("R10 requests of both runs", nreq, 6);
    auto_on = 1'b0;

    report();
  end

endmodule